// File: doc/BRIEF.md
# Conditional Branch Next-PC Unit

This block owns the program counter of a small 16-bit processor and decides, once per accepted instruction, where the next fetch comes from. Instructions are 16-bit words in byte-addressed memory, so the ordinary successor of an instruction lies two bytes further on. Two instruction classes change that flow. A branch compares the status flags with a 3-bit condition and, if the condition holds, moves the PC by a signed word offset taken from the instruction. A jump replaces the PC with the contents of a general register.

The surrounding core presents the instruction word, the zero and negative flags, and the value of the register named by the instruction. The unit drives the number of that register back out so that a register file can be read combinationally. An advance input says when the current instruction is retired. Only then does the PC register take its new value. A jump to an odd address is forced onto the even word below it and reported on a one-cycle misalignment output.

Top module: `branch_npc_unit`

## Requirements
- R1: While rstN is low, and in the first cycle after it is released, pcOut is 0x0000 and misaligned is 0.
- R2: In a cycle where advance is 0, pcOut keeps its value across the clock edge and misaligned is 0 after that edge.
- R3: With advance at 1, an opcode (instrWord[15:12]) other than 0110 and 0111 loads pcOut + 2, modulo 2^16.
- R4: A branch is opcode 0110, with its condition in instrWord[11:9] and a signed offset in instrWord[7:0]. When it is taken and advance is 1, the PC becomes pcOut + 2 + 2*offset, modulo 2^16. When it is not taken, the PC becomes pcOut + 2.
- R5: With flags Z (flagZero) and N (flagNeg), the conditions are: 000 taken if Z; 001 if !Z; 010 if !Z and !N; 011 if !N; 100 if N; 101 if N or Z; 111 always.
- R6: Condition code 110 is never taken, whatever the flags.
- R7: A jump is opcode 0111 with its register field in instrWord[11:9]. regSel always equals instrWord[11:9]. With advance at 1, the PC becomes regValue with bit 0 cleared.
- R8: misaligned is 1 in the cycle after an accepted jump whose regValue has bit 0 set, and 0 in every other cycle.
- R9: instrWord[8:0] of a jump and instrWord[8] of a branch have no effect on the next PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| advance | input | 1 | Retire current instruction and update the PC |
| instrWord | input | 16 | Instruction being retired |
| flagZero | input | 1 | Zero status flag |
| flagNeg | input | 1 | Negative status flag |
| regValue | input | 16 | Value of the register named by regSel |
| regSel | output | 3 | Register field of the instruction |
| pcOut | output | 16 | Current program counter |
| misaligned | output | 1 | Odd jump target was rounded down (one cycle) |

## Verification
The hardest situations to reach from the ports are the ones that depend on what the PC already holds. A backward offset has to cross address zero, and a sequential step has to wrap from 0xFFFE. The stimulus therefore first jumps to chosen addresses near both ends of the space and only then issues branches and plain steps. A second hard case is two odd-target jumps in a row, where misaligned must stay high across consecutive cycles and drop on the next ordinary instruction. Another is an odd jump presented while advance is low, which must leave no trace. A long run of random instructions then follows, weighted toward branches and jumps, with every flag combination and every condition code including the reserved one.

// File: rtl/bnpu_pkg.sv
package bnpu_pkg;
  localparam int unsigned OPC_W = 4;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 4'b0110;
  localparam logic [OPC_W-1:0] OPC_JUMP   = 4'b0111;

  typedef enum logic [2:0] {
    COND_EQ   = 3'b000,
    COND_NE   = 3'b001,
    COND_GT   = 3'b010,
    COND_GE   = 3'b011,
    COND_LT   = 3'b100,
    COND_LE   = 3'b101,
    COND_RSV  = 3'b110,
    COND_ALL  = 3'b111
  } condCode_t;

  typedef struct packed {
    logic load;
    logic takeBranch;
    logic takeJump;
  } pcStrobes_t;
endpackage

// File: rtl/bnpu_ctrl.sv
module bnpu_ctrl
  import bnpu_pkg::*;
#(
  parameter int unsigned INSTR_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               advance,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic               flagZero,
  input  logic               flagNeg,
  output logic [2:0]         regSel,
  output pcStrobes_t         strobes
);
  localparam int unsigned OPC_LSB = INSTR_W - OPC_W;

  logic [OPC_W-1:0] opcode;
  condCode_t        cond;
  logic             condMet;

  assign opcode = instrWord[INSTR_W-1:OPC_LSB];
  assign regSel = instrWord[OPC_LSB-1:OPC_LSB-3];
  assign cond   = condCode_t'(regSel);

  always_comb begin
    unique case (cond)
      COND_EQ:  condMet = flagZero;
      COND_NE:  condMet = !flagZero;
      COND_GT:  condMet = !flagZero && !flagNeg;
      COND_GE:  condMet = !flagNeg;
      COND_LT:  condMet = flagNeg;
      COND_LE:  condMet = flagNeg || flagZero;
      COND_RSV: condMet = 1'b0;
      COND_ALL: condMet = 1'b1;
      default:  condMet = 1'b0;
    endcase
  end

  always_comb begin
    strobes.load       = advance;
    strobes.takeBranch = (opcode == OPC_BRANCH) && condMet;
    strobes.takeJump   = (opcode == OPC_JUMP);
  end

  // R6: reserved condition never produces a taken branch
  a_r6_reserved_never: assert property (@(posedge clk) disable iff (!rstN)
    (instrWord[INSTR_W-1:OPC_LSB] == OPC_BRANCH && instrWord[OPC_LSB-1:OPC_LSB-3] == 3'b110)
      |-> !strobes.takeBranch);

  // R4 / R7: branch and jump selections are exclusive
  a_r4_sel_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.takeBranch, strobes.takeJump}));
endmodule

// File: rtl/bnpu_dpath.sv
module bnpu_dpath
  import bnpu_pkg::*;
#(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned OFF_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  pcStrobes_t       strobes,
  input  logic [OFF_W-1:0] offset,
  input  logic [PC_W-1:0]  regValue,
  output logic [PC_W-1:0]  pcOut,
  output logic             misaligned
);
  localparam int unsigned EXT_W = PC_W - OFF_W - 1;
  localparam logic [PC_W-1:0] STEP = PC_W'(2);

  logic [PC_W-1:0] pcQ;
  logic [PC_W-1:0] seqPc;
  logic [PC_W-1:0] offBytes;
  logic [PC_W-1:0] branchPc;
  logic [PC_W-1:0] jumpPc;
  logic [PC_W-1:0] nextPc;
  logic            misQ;

  assign seqPc    = pcQ + STEP;
  assign offBytes = {{EXT_W{offset[OFF_W-1]}}, offset, 1'b0};
  assign branchPc = seqPc + offBytes;
  assign jumpPc   = {regValue[PC_W-1:1], 1'b0};

  always_comb begin
    if (strobes.takeJump)        nextPc = jumpPc;
    else if (strobes.takeBranch) nextPc = branchPc;
    else                         nextPc = seqPc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ  <= '0;
      misQ <= 1'b0;
    end else begin
      misQ <= strobes.load && strobes.takeJump && regValue[0];
      if (strobes.load) pcQ <= nextPc;
    end
  end

  assign pcOut      = pcQ;
  assign misaligned = misQ;

  // R2: PC holds when the instruction is not retired
  a_r2_hold_pc: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(pcQ));

  // R7: PC never holds an odd address
  a_r7_pc_even: assert property (@(posedge clk) disable iff (!rstN)
    pcQ[0] == 1'b0);

  // R8: misalignment only follows an accepted jump
  a_r8_mis_after_jump: assert property (@(posedge clk) disable iff (!rstN)
    $rose(misQ) |-> $past(strobes.load && strobes.takeJump));
endmodule

// File: rtl/branch_npc_unit.sv
module branch_npc_unit
  import bnpu_pkg::*;
#(
  parameter int unsigned PC_W    = 16,
  parameter int unsigned INSTR_W = 16,
  parameter int unsigned OFF_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               advance,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic               flagZero,
  input  logic               flagNeg,
  input  logic [PC_W-1:0]    regValue,
  output logic [2:0]         regSel,
  output logic [PC_W-1:0]    pcOut,
  output logic               misaligned
);
  pcStrobes_t strobes;

  bnpu_ctrl #(.INSTR_W(INSTR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .advance   (advance),
    .instrWord (instrWord),
    .flagZero  (flagZero),
    .flagNeg   (flagNeg),
    .regSel    (regSel),
    .strobes   (strobes)
  );

  bnpu_dpath #(.PC_W(PC_W), .OFF_W(OFF_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .offset     (instrWord[OFF_W-1:0]),
    .regValue   (regValue),
    .pcOut      (pcOut),
    .misaligned (misaligned)
  );

  // R8: misaligned is a registered pulse, never set while in reset
  a_r8_clear_after_idle: assert property (@(posedge clk) disable iff (!rstN)
    !advance |=> !misaligned);
endmodule

// File: tb/branch_npc_unit_tb.sv
module branch_npc_unit_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        advance;
  logic [15:0] instrWord;
  logic        flagZero;
  logic        flagNeg;
  logic [15:0] regValue;
  logic [2:0]  regSel;
  logic [15:0] pcOut;
  logic        misaligned;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  int expPc = 0;
  bit expMis = 0;

  always #10 clk = ~clk;

  branch_npc_unit u_dut (
    .clk(clk), .rstN(rstN), .advance(advance), .instrWord(instrWord),
    .flagZero(flagZero), .flagNeg(flagNeg), .regValue(regValue),
    .regSel(regSel), .pcOut(pcOut), .misaligned(misaligned)
  );

  function automatic bit condHolds(input logic [2:0] c, input logic z, input logic n);
    case (c)
      3'd0: return z;
      3'd1: return !z;
      3'd2: return !z && !n;
      3'd3: return !n;
      3'd4: return n;
      3'd5: return n || z;
      3'd7: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp, input string what);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] iw, input logic z, input logic n,
                      input logic [15:0] rv, input logic adv, input string tag);
    int nxt;
    int off;
    @(negedge clk);
    instrWord = iw; flagZero = z; flagNeg = n; regValue = rv; advance = adv;
    #1;
    check("R7", regSel, iw[11:9], "regSel");
    nxt = expPc;
    expMis = 0;
    if (adv) begin
      if (iw[15:12] == 4'b0111) begin
        nxt = rv & 16'hFFFE;
        expMis = rv[0];
      end else if (iw[15:12] == 4'b0110 && condHolds(iw[11:9], z, n)) begin
        off = int'($signed(iw[7:0]));
        nxt = (expPc + 2 + 2 * off) & 16'hFFFF;
      end else begin
        nxt = (expPc + 2) & 16'hFFFF;
      end
    end
    @(posedge clk);
    #2;
    expPc = nxt;
    check(tag, pcOut, expPc, "pcOut");
    check(tag, misaligned, expMis, "misaligned");
  endtask

  function automatic logic [15:0] br(input logic [2:0] c, input logic [7:0] off);
    return {4'b0110, c, 1'b0, off};
  endfunction

  function automatic logic [15:0] jmp(input logic [2:0] r);
    return {4'b0111, r, 9'd0};
  endfunction

  initial begin
    #(20 * 200000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rstN = 0; advance = 1; instrWord = 16'h0000; flagZero = 0; flagNeg = 0; regValue = 16'h0001;
    repeat (3) @(negedge clk);
    check("R1", pcOut, 0, "pcOut in reset");
    check("R1", misaligned, 0, "misaligned in reset");
    rstN = 1; advance = 0;
    #1;
    check("R1", pcOut, 0, "pcOut after release");
    expPc = 0;

    // R3: sequential steps with several opcodes
    step(16'h0123, 0, 0, 16'h0, 1, "R3");
    step(16'h5FFF, 1, 1, 16'h0, 1, "R3");
    step(16'hF000, 0, 1, 16'h0, 1, "R3");
    // R2: hold while advance is low, even for a jump or branch
    step(jmp(3'd2), 0, 0, 16'h4001, 0, "R2");
    step(br(3'd7, 8'h10), 0, 0, 16'h0, 0, "R2");
    // R7: jump to top of space, then R3 wrap
    step(jmp(3'd5), 0, 0, 16'hFFFE, 1, "R7");
    step(16'h1000, 0, 0, 16'h0, 1, "R3");
    // R4: backward offset crossing zero, forward offset
    step(br(3'd7, 8'h80), 0, 0, 16'h0, 1, "R4");
    step(br(3'd7, 8'h7F), 0, 0, 16'h0, 1, "R4");
    step(br(3'd7, 8'hFF), 0, 0, 16'h0, 1, "R4");
    // R5: every condition with every flag combination
    for (int c = 0; c < 8; c++) begin
      for (int f = 0; f < 4; f++) begin
        if (c == 6) step(br(3'(c), 8'h05), f[0], f[1], 16'h0, 1, "R6");
        else        step(br(3'(c), 8'h05), f[0], f[1], 16'h0, 1, "R5");
      end
    end
    // R8: odd jump, back-to-back odd jumps, then clear
    step(jmp(3'd1), 0, 0, 16'h1235, 1, "R8");
    step(jmp(3'd3), 0, 0, 16'h0101, 1, "R8");
    step(16'h2000, 0, 0, 16'hFFFF, 1, "R8");
    step(jmp(3'd4), 0, 0, 16'h3333, 0, "R8");
    step(jmp(3'd0), 0, 0, 16'h8000, 1, "R8");
    // R9: nonzero reserved bits in jump and branch
    step({4'b0111, 3'd6, 9'h1FF}, 0, 0, 16'h0400, 1, "R9");
    step({4'b0110, 3'd7, 1'b1, 8'h03}, 0, 0, 16'h0, 1, "R9");
    step({4'b0110, 3'd0, 1'b1, 8'h03}, 0, 0, 16'h0, 1, "R9");
    // R1: reset again in mid-run
    @(negedge clk); rstN = 0; advance = 1;
    @(negedge clk); rstN = 1; advance = 0;
    #1;
    check("R1", pcOut, 0, "pcOut after mid reset");
    check("R1", misaligned, 0, "misaligned after mid reset");
    expPc = 0;
    // random mix, weighted toward branch and jump
    for (int i = 0; i < 400; i++) begin
      logic [15:0] w;
      int sel;
      w = 16'($urandom);
      sel = $urandom_range(0, 9);
      if (sel < 4) w[15:12] = 4'b0110;
      else if (sel < 6) w[15:12] = 4'b0111;
      step(w, 1'($urandom), 1'($urandom), 16'($urandom), ($urandom_range(0, 7) != 0),
           (w[15:12] == 4'b0111) ? "R7" : (w[15:12] == 4'b0110) ? "R5" : "R3");
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule